// File: doc/BRIEF.md
# Digital Potentiometer Register Controller

This block keeps the state behind a 128-step digital potentiometer. It holds the live wiper position and a modelled non-volatile start-up position, plus a control byte. An SPI front end, outside this block, turns bus traffic into single-cycle read and write requests and a pulse that marks the end of each bus transaction. The block drives two signals to the resistor array: the wiper code and a shutdown flag.

The live position and the stored start-up position share one address. A select bit in the control byte picks which of the two that address reaches. A write that reaches the stored position also moves the wiper at once. It then starts a self-timed programming cycle when the transaction closes. A busy flag covers that cycle and locks out all writes until it ends. After reset the wiper sits at mid-scale and is then reloaded from the stored value. Shutdown is requested either by the control byte or by an active-low pin. The wiper code survives shutdown unchanged.

Top module: `dpot_ctrl`

## Requirements
- R1: While reset is high and until the recall completes, the wiper output is 64 (mid-scale). Reset also clears the volatile select bit to 0, sets the run bit to 1, clears the busy flag, clears read data to 0 and clears the shutdown output to 0. Reset does not alter the stored value.
- R2: Exactly RECALL_CYCLES clock edges after reset is released, the wiper takes the stored value. Every write issued before that edge is ignored.
- R3: Address 2'b00 reaches the wiper or the stored value, and address 2'b10 reaches the control byte. Reads of 2'b01 and 2'b11 return 0, and writes to them change nothing.
- R4: The control byte reads as bit 7 = volatile select, bit 6 = run bit (0 requests shutdown), bit 5 = busy and bits 4:0 = 0. Written values of bits 5:0 are discarded.
- R5: With the volatile select bit at 1, a write to 2'b00 loads data bits 6:0 into the wiper on the next edge and leaves the stored value untouched. A read of 2'b00 returns the wiper.
- R6: With the volatile select bit at 0, a write to 2'b00 loads the wiper on the next edge and arms a store of the same value. A read of 2'b00 returns the stored value, which is the old one until programming ends, and never changes the wiper.
- R7: An end-of-transaction pulse with a store armed sets busy on that edge. Busy stays high for exactly NV_CYCLES cycles, and the stored value takes the new data on the edge where busy falls. An end pulse with nothing armed does nothing.
- R8: While busy is 1, every write request is ignored: the wiper, the control byte and the stored value are left unchanged.
- R9: The shutdown output is registered. It is 1 on the edge after the run bit is 0 or the pin is low, and 0 otherwise. Reads and writes work normally in shutdown, and the wiper output keeps its code through it.
- R10: Read data is updated on the edge that samples a read request, and it holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Single-cycle access request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 2 | Register address |
| req_wdata | input | 8 | Write data byte |
| txn_end | input | 1 | Pulse at the close of a bus transaction |
| shdn_pin_n | input | 1 | External shutdown request, active low |
| rd_data | output | 8 | Registered read data |
| wiper_pos | output | WIPER_W | Wiper code to the resistor array |
| shut_o | output | 1 | Array shutdown flag |

## Verification
The assertions assume the following about the inputs. The SPI front end never raises txn_end in the same cycle as a write request. Address and data are valid whenever req_valid is high. The shutdown pin is already synchronous to clk. The stimulus drives one request at a time at the falling clock edge. It puts idle cycles between each write and its transaction-end pulse. It holds the pin steady across each edge.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
  localparam int unsigned DATA_W = 8;
  localparam logic [1:0] ADDR_POS = 2'b00;
  localparam logic [1:0] ADDR_CTL = 2'b10;
  localparam int unsigned BIT_VSEL = 7;
  localparam int unsigned BIT_RUN  = 6;
  localparam int unsigned BIT_BUSY = 5;
  localparam int unsigned MID_CODE = 64;
endpackage

// File: rtl/dpot_nv_cell.sv
module dpot_nv_cell #(
  parameter int unsigned W         = 7,
  parameter int unsigned NV_CYCLES = 5_000_000,
  parameter int unsigned NV_INIT   = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_req,
  input  logic [W-1:0] wr_data,
  input  logic         txn_end,
  output logic [W-1:0] nv_q,
  output logic         busy
);
  localparam int unsigned CW = (NV_CYCLES > 1) ? $clog2(NV_CYCLES) : 1;

  logic [CW-1:0] cnt_q;
  logic [W-1:0]  pend_q;
  logic          armed_q;
  logic          busy_q;
  logic [W-1:0]  store_q = W'(NV_INIT);

  wire done = busy_q && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      armed_q <= 1'b0;
      pend_q  <= '0;
    end else begin
      if (busy_q) begin
        if (done) busy_q <= 1'b0;
        else      cnt_q  <= cnt_q - 1'b1;
      end else if (txn_end && armed_q) begin
        busy_q  <= 1'b1;
        cnt_q   <= CW'(NV_CYCLES - 1);
        armed_q <= 1'b0;
      end
      if (wr_req) begin
        pend_q  <= wr_data;
        armed_q <= 1'b1;
      end
    end
  end

  // the stored value is not cleared by reset: it models a persistent cell
  always_ff @(posedge clk) begin
    if (!rst && done) store_q <= pend_q;
  end

  assign nv_q = store_q;
  assign busy = busy_q;
endmodule

// File: rtl/dpot_recall.sv
module dpot_recall #(
  parameter int unsigned RECALL_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  output logic busy,
  output logic load
);
  localparam int unsigned RW = $clog2(RECALL_CYCLES + 1);

  logic [RW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= RW'(RECALL_CYCLES);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);
  assign load = (cnt_q == RW'(1));
endmodule

// File: rtl/dpot_ctrl.sv
module dpot_ctrl
  import dpot_pkg::*;
#(
  parameter int unsigned WIPER_W       = 7,
  parameter int unsigned NV_CYCLES     = 5_000_000,
  parameter int unsigned RECALL_CYCLES = 16,
  parameter int unsigned NV_INIT       = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [1:0]         req_addr,
  input  logic [7:0]         req_wdata,
  input  logic               txn_end,
  input  logic               shdn_pin_n,
  output logic [7:0]         rd_data,
  output logic [WIPER_W-1:0] wiper_pos,
  output logic               shut_o
);
  localparam int unsigned PAD_W = DATA_W - WIPER_W;

  logic               vsel_q, run_q, shut_q;
  logic [WIPER_W-1:0] wiper_q;
  logic [7:0]         rd_q, rd_mux;
  logic [WIPER_W-1:0] nv_q;
  logic               nv_busy, rec_busy, rec_load;

  wire hit_pos = (req_addr == ADDR_POS);
  wire hit_ctl = (req_addr == ADDR_CTL);
  wire rd_ok   = req_valid && !req_write;
  wire wr_ok   = req_valid && req_write && !nv_busy && !rec_busy;
  wire nv_wr   = wr_ok && hit_pos && !vsel_q;

  dpot_recall #(.RECALL_CYCLES(RECALL_CYCLES)) u_recall (
    .clk (clk),
    .rst (rst),
    .busy(rec_busy),
    .load(rec_load)
  );

  dpot_nv_cell #(.W(WIPER_W), .NV_CYCLES(NV_CYCLES), .NV_INIT(NV_INIT)) u_nv (
    .clk    (clk),
    .rst    (rst),
    .wr_req (nv_wr),
    .wr_data(req_wdata[WIPER_W-1:0]),
    .txn_end(txn_end),
    .nv_q   (nv_q),
    .busy   (nv_busy)
  );

  always_comb begin
    rd_mux = '0;
    if (hit_pos) begin
      rd_mux = {{PAD_W{1'b0}}, (vsel_q ? wiper_q : nv_q)};
    end else if (hit_ctl) begin
      rd_mux[BIT_VSEL] = vsel_q;
      rd_mux[BIT_RUN]  = run_q;
      rd_mux[BIT_BUSY] = nv_busy;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vsel_q  <= 1'b0;
      run_q   <= 1'b1;
      shut_q  <= 1'b0;
      rd_q    <= '0;
      wiper_q <= WIPER_W'(MID_CODE);
    end else begin
      shut_q <= !run_q || !shdn_pin_n;
      if (rec_load)                wiper_q <= nv_q;
      else if (wr_ok && hit_pos)   wiper_q <= req_wdata[WIPER_W-1:0];
      if (wr_ok && hit_ctl) begin
        vsel_q <= req_wdata[BIT_VSEL];
        run_q  <= req_wdata[BIT_RUN];
      end
      if (rd_ok) rd_q <= rd_mux;
    end
  end

  assign rd_data   = rd_q;
  assign wiper_pos = wiper_q;
  assign shut_o    = shut_q;
endmodule

// File: rtl/dpot_ctrl_chk.sv
module dpot_ctrl_chk #(
  parameter int unsigned WIPER_W = 7
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic               req_write,
  input logic [1:0]         req_addr,
  input logic               shdn_pin_n,
  input logic [7:0]         rd_data,
  input logic [WIPER_W-1:0] wiper_pos,
  input logic               shut_o,
  input logic               busy,
  input logic [WIPER_W-1:0] nv_q
);
  p_busy_blocks_wiper_r8: assert property (@(posedge clk) disable iff (rst)
    busy && req_valid && req_write |=> $stable(wiper_pos));

  p_store_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !busy |=> $stable(nv_q));

  p_ctl_pad_zero_r4: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_write && req_addr == 2'b10 |=> rd_data[4:0] == 5'd0);

  p_reserved_zero_r3: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_write && req_addr[0] |=> rd_data == 8'd0);

  p_pin_shuts_r9: assert property (@(posedge clk) disable iff (rst)
    !shdn_pin_n |=> shut_o);

  p_rd_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && !req_write) |=> $stable(rd_data));
endmodule

bind dpot_ctrl dpot_ctrl_chk #(.WIPER_W(WIPER_W)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr  (req_addr),
  .shdn_pin_n(shdn_pin_n),
  .rd_data   (rd_data),
  .wiper_pos (wiper_pos),
  .shut_o    (shut_o),
  .busy      (nv_busy),
  .nv_q      (nv_q)
);

// File: tb/test_dpot_ctrl.sv
module test_dpot_ctrl;
  localparam int NV  = 40;
  localparam int REC = 8;
  localparam int INI = 21;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, txn_end = 1'b0, pin_n = 1'b1;
  logic [1:0] req_addr = 2'b00;
  logic [7:0] req_wdata = 8'h00;
  logic [7:0] rd_data;
  logic [6:0] wiper_pos;
  logic shut_o;

  int tests = 0, fails = 0;

  always #2 clk = ~clk;

  dpot_ctrl #(.WIPER_W(7), .NV_CYCLES(NV), .RECALL_CYCLES(REC), .NV_INIT(INI)) i_dpot_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .txn_end(txn_end),
    .shdn_pin_n(pin_n), .rd_data(rd_data), .wiper_pos(wiper_pos), .shut_o(shut_o));

  // behavioural reference
  logic [6:0] m_wiper, m_nv = 7'(INI), m_pend;
  logic [7:0] m_rd;
  logic m_vol, m_run, m_wip, m_armed, m_shut, started = 1'b0;
  int m_left, m_rec;

  always @(posedge clk) begin
    logic o_vol, o_run, o_wip;
    logic [6:0] o_wiper, o_nv;
    int o_rec;
    o_vol = m_vol; o_run = m_run; o_wip = m_wip; o_wiper = m_wiper; o_nv = m_nv; o_rec = m_rec;
    if (rst) begin
      m_wiper = 7'd64; m_vol = 0; m_run = 1; m_wip = 0; m_armed = 0;
      m_rd = 0; m_shut = 0; m_rec = REC; m_left = 0; m_pend = 0;
    end else begin
      m_shut = !o_run || !pin_n;
      if (o_rec != 0) begin
        if (o_rec == 1) m_wiper = o_nv;
        m_rec = o_rec - 1;
      end
      if (o_wip) begin
        if (m_left == 1) begin m_nv = m_pend; m_wip = 0; end
        m_left = m_left - 1;
      end else if (txn_end && m_armed) begin
        m_wip = 1; m_left = NV; m_armed = 0;
      end
      if (req_valid && !req_write)
        m_rd = (req_addr == 2'd0) ? {1'b0, (o_vol ? o_wiper : o_nv)} :
               (req_addr == 2'd2) ? {o_vol, o_run, o_wip, 5'd0} : 8'd0;
      if (req_valid && req_write && !o_wip && o_rec == 0) begin
        if (req_addr == 2'd0) begin
          m_wiper = req_wdata[6:0];
          if (!o_vol) begin m_pend = req_wdata[6:0]; m_armed = 1; end
        end else if (req_addr == 2'd2) begin
          m_vol = req_wdata[7]; m_run = req_wdata[6];
        end
      end
    end
    started = 1'b1;
  end

  always @(negedge clk) begin
    if (started) begin
      tests++;
      if (wiper_pos !== m_wiper) begin
        fails++; $display("FAIL R5 wiper actual=%0h expected=%0h", wiper_pos, m_wiper);
      end
      tests++;
      if (rd_data !== m_rd) begin
        fails++; $display("FAIL R10 rd_data actual=%0h expected=%0h", rd_data, m_rd);
      end
      tests++;
      if (shut_o !== m_shut) begin
        fails++; $display("FAIL R9 shut actual=%0b expected=%0b", shut_o, m_shut);
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(input logic [1:0] a);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic end_txn();
    @(negedge clk); txn_end = 1;
    @(negedge clk); txn_end = 0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #200000;
    tests++; fails++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    idle(4);
    check("R1 reset wiper", wiper_pos, 64);
    check("R1 reset rd_data", rd_data, 0);
    check("R1 reset shut", shut_o, 0);
    rst = 0;
    wr(2'd2, 8'hC0);                       // R2: ignored during recall
    check("R2 wiper mid before recall", wiper_pos, 64);
    idle(REC);
    check("R2 recalled wiper", wiper_pos, INI);
    rd(2'd2); check("R2 early write ignored / R4 ctl reset", rd_data, 8'h40);
    rd(2'd0); check("R6 read stored", rd_data, INI);
    rd(2'd1); check("R3 reserved 01 reads 0", rd_data, 0);
    wr(2'd3, 8'hFF);
    rd(2'd3); check("R3 reserved 11 reads 0", rd_data, 0);
    rd(2'd2); check("R3 reserved write no effect", rd_data, 8'h40);
    wr(2'd2, 8'hBF);                       // vol=1, run=0, junk low bits
    idle(1);
    check("R9 shutdown by run bit", shut_o, 1);
    check("R9 wiper kept in shutdown", wiper_pos, INI);
    rd(2'd2); check("R4 ctl low bits discarded", rd_data, 8'h80);
    wr(2'd2, 8'hDF);
    rd(2'd2); check("R4 busy bit read only", rd_data, 8'hC0);
    idle(1);
    check("R9 leave shutdown", shut_o, 0);
    wr(2'd0, 8'h7F);
    check("R5 volatile write", wiper_pos, 8'h7F);
    rd(2'd0); check("R5 read wiper", rd_data, 8'h7F);
    end_txn(); idle(2);
    wr(2'd2, 8'h40);
    rd(2'd0); check("R5 stored untouched", rd_data, INI);
    check("R6 read keeps wiper", wiper_pos, 8'h7F);
    wr(2'd0, 8'h33);
    check("R6 wiper loaded", wiper_pos, 8'h33);
    idle(2);
    end_txn();
    rd(2'd2); check("R7 busy set", rd_data, 8'h60);
    rd(2'd0); check("R6 old stored during busy", rd_data, INI);
    wr(2'd2, 8'h80);
    wr(2'd0, 8'h11);
    check("R8 wiper write ignored", wiper_pos, 8'h33);
    rd(2'd2); check("R8 ctl write ignored", rd_data, 8'h60);
    idle(NV);
    rd(2'd2); check("R7 busy cleared", rd_data, 8'h40);
    rd(2'd0); check("R7 stored updated", rd_data, 8'h33);
    end_txn(); idle(2);
    rd(2'd2); check("R7 end pulse without store", rd_data, 8'h40);
    pin_n = 0; idle(2);
    check("R9 pin shutdown", shut_o, 1);
    wr(2'd2, 8'hC0);
    wr(2'd0, 8'h05);
    check("R9 access in shutdown", wiper_pos, 8'h05);
    pin_n = 1; idle(2);
    check("R9 restore keeps wiper", wiper_pos, 8'h05);
    rd(2'd2); check("R10 read after shutdown", rd_data, 8'hC0);
    idle(3);
    check("R10 rd held", rd_data, 8'hC0);
    @(negedge clk); rst = 1; idle(3);
    check("R1 second reset mid", wiper_pos, 64);
    rst = 0; idle(REC);
    check("R2 recall after reset", wiper_pos, 8'h33);
    idle(4);
    summary();
  end
endmodule